// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block generates the source and destination addresses for a single DMA channel and tracks how far the channel has progressed. Software programs a set of shadow values through a small write port: the start addresses, the burst, transfer and wrap sizes, the signed per-word and per-wrap steps, and the mode bits. A start trigger begins a transfer. A strobe then reports each word that has been moved, and the block advances its pointers and counters in response.

A transfer consists of a number of bursts, and each burst consists of a number of 16-bit units. After each word, the source and destination pointers move by their own signed burst step. Each direction has its own wrap counter, which counts bursts. When that counter expires, the pointer jumps to a wrap base that has moved by a signed wrap step, which gives circular addressing. The block reports the end of each burst, so that an arbiter can move on to another channel. It also reports the end of each transfer and raises a one-cycle channel interrupt, either at the start or at the end of the transfer depending on a mode bit.

Top module: `dma_addr_seq`

## Requirements
- R1: After a synchronous reset, both addresses are 0 and `busy_o`, `burst_done_o`, `xfer_done_o` and `irq_o` are 0.
- R2: A start (`start_i` high at a clock edge while the channel is enabled and idle) loads the shadow start addresses into `src_addr_o`/`dst_addr_o` and raises `busy_o`, both visible after that edge. A start while the channel is disabled or busy has no effect. Register select codes are: 0 source start, 1 destination start, 2 burst size, 3 transfer size, 4 source wrap size, 5 destination wrap size, 6 source burst step, 7 destination burst step, 8 source wrap step, 9 destination wrap step, 10 mode. The mode bits are: bit0 enable, bit1 interrupt-at-start, bit2 continuous, bit3 32-bit words.
- R3: A word strobe that does not end a burst moves each address by its signed two's-complement burst step. The step may be negative or zero.
- R4: Every size field holds the count minus one. In 16-bit mode, `burst_done_o` pulses for one cycle after the (burst size + 1)-th word of a burst.
- R5: In 32-bit mode, each word counts as two 16-bit units. A burst size of 5 therefore ends the burst after 3 words.
- R6: `xfer_done_o` pulses together with `burst_done_o` after the (transfer size + 1)-th burst, and `busy_o` then falls. The addresses do not move on that final word. Word strobes while idle have no effect.
- R7: Each direction has its own wrap counter, which counts bursts. After (wrap size + 1) bursts, the wrap base is advanced by the signed wrap step and the address is loaded from the new base. This takes priority over the burst step on that word.
- R8: A wrap size greater than or equal to the transfer size produces no wrap within the transfer.
- R9: `irq_o` is a one-cycle pulse. With interrupt-at-start set, it follows the start edge. Otherwise it follows the final word of the transfer.
- R10: With continuous clear, the channel disables itself at the end of the transfer, so a later start is ignored until the enable bit is written again. With continuous set, the channel stays enabled.
- R11: Register writes made during a transfer change only the shadow values. They take effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Shadow register write strobe |
| cfg_sel_i | input | 4 | Shadow register select code |
| cfg_wdata_i | input | ADDR_W | Write data (low bits used for narrower fields) |
| start_i | input | 1 | Start-transfer trigger |
| word_i | input | 1 | One word has been transferred |
| src_addr_o | output | ADDR_W | Active source address |
| dst_addr_o | output | ADDR_W | Active destination address |
| busy_o | output | 1 | Transfer in progress |
| burst_done_o | output | 1 | One-cycle pulse after the last word of a burst |
| xfer_done_o | output | 1 | One-cycle pulse after the last word of a transfer |
| irq_o | output | 1 | One-cycle channel interrupt |

## Verification
Every internal counter or pointer that goes wrong becomes visible on the address ports within one cycle of the word in question. A burst counter that is off by one shifts the `burst_done_o` pulse by a word. It also puts the wrap jump on the wrong word, where the address takes the step value instead of the base value. A wrong wrap base shows up only on the second wrap of a direction, so the wrap scenario runs enough bursts to wrap twice on the source side. A stale mode or size latch shows up on the second transfer after a mid-transfer write, or on a start that should have been refused.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [3:0] {
    SEL_SRC_START  = 4'd0,
    SEL_DST_START  = 4'd1,
    SEL_BURST_SIZE = 4'd2,
    SEL_XFER_SIZE  = 4'd3,
    SEL_SRC_WSIZE  = 4'd4,
    SEL_DST_WSIZE  = 4'd5,
    SEL_SRC_BSTEP  = 4'd6,
    SEL_DST_BSTEP  = 4'd7,
    SEL_SRC_WSTEP  = 4'd8,
    SEL_DST_WSTEP  = 4'd9,
    SEL_MODE       = 4'd10
  } cfg_sel_e;

  typedef struct packed {
    logic wide;
    logic cont;
    logic irq_at_start;
    logic en;
  } mode_t;

endpackage

// File: rtl/dma_seq_ptr.sv
module dma_seq_ptr #(
  parameter int ADDR_W = 24,
  parameter int STEP_W = 16,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [SIZE_W-1:0] wrap_size_i,
  input  logic [STEP_W-1:0] burst_step_i,
  input  logic [STEP_W-1:0] wrap_step_i,
  input  logic              adv_i,
  input  logic              burst_end_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int EXT_W = ADDR_W - STEP_W;

  logic [ADDR_W-1:0] addr_q, base_q, bstep_x, wstep_x, next_base;
  logic [SIZE_W-1:0] wcnt_q, wsize_q;
  logic [STEP_W-1:0] bstep_q, wstep_q;

  // sign extension of the latched steps to address width
  assign bstep_x   = {{EXT_W{bstep_q[STEP_W-1]}}, bstep_q};
  assign wstep_x   = {{EXT_W{wstep_q[STEP_W-1]}}, wstep_q};
  assign next_base = base_q + wstep_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      base_q  <= '0;
      wcnt_q  <= '0;
      wsize_q <= '0;
      bstep_q <= '0;
      wstep_q <= '0;
    end else if (load_i) begin
      addr_q  <= start_addr_i;
      base_q  <= start_addr_i;
      wcnt_q  <= wrap_size_i;
      wsize_q <= wrap_size_i;
      bstep_q <= burst_step_i;
      wstep_q <= wrap_step_i;
    end else if (adv_i) begin
      if (burst_end_i && (wcnt_q == '0)) begin
        // wrap wins over the burst step on this word
        base_q <= next_base;
        addr_q <= next_base;
        wcnt_q <= wsize_q;
      end else begin
        if (burst_end_i) wcnt_q <= wcnt_q - 1'b1;
        addr_q <= addr_q + bstep_x;
      end
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dma_seq_ctl.sv
module dma_seq_ctl
  import dma_seq_pkg::*;
#(
  parameter int BURST_W = 5,
  parameter int SIZE_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               word_i,
  input  mode_t              mode_i,
  input  logic [BURST_W-1:0] burst_size_i,
  input  logic [SIZE_W-1:0]  xfer_size_i,
  output logic               load_o,
  output logic               adv_o,
  output logic               burst_end_o,
  output logic               en_clr_o,
  output logic               busy_o,
  output logic               burst_done_o,
  output logic               xfer_done_o,
  output logic               irq_o
);

  logic               busy_q, bd_q, xd_q, irq_q;
  logic [BURST_W-1:0] bcnt_q, bsize_l;
  logic [SIZE_W-1:0]  xcnt_q;
  logic               at_start_l, cont_l, wide_l;
  logic               last_unit, bend, xend;
  logic [BURST_W-1:0] dec;

  assign load_o    = start_i & mode_i.en & ~busy_q;
  assign last_unit = wide_l ? (bcnt_q <= BURST_W'(1)) : (bcnt_q == '0);
  assign bend      = busy_q & word_i & last_unit;
  assign xend      = bend & (xcnt_q == '0);
  assign dec       = wide_l ? BURST_W'(2) : BURST_W'(1);

  assign adv_o       = busy_q & word_i & ~xend;
  assign burst_end_o = bend;
  assign en_clr_o    = xend & ~cont_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      bd_q       <= 1'b0;
      xd_q       <= 1'b0;
      irq_q      <= 1'b0;
      bcnt_q     <= '0;
      bsize_l    <= '0;
      xcnt_q     <= '0;
      at_start_l <= 1'b0;
      cont_l     <= 1'b0;
      wide_l     <= 1'b0;
    end else begin
      bd_q  <= bend;
      xd_q  <= xend;
      irq_q <= (load_o & mode_i.irq_at_start) | (xend & ~at_start_l);
      if (load_o) begin
        busy_q     <= 1'b1;
        bcnt_q     <= burst_size_i;
        bsize_l    <= burst_size_i;
        xcnt_q     <= xfer_size_i;
        at_start_l <= mode_i.irq_at_start;
        cont_l     <= mode_i.cont;
        wide_l     <= mode_i.wide;
      end else if (busy_q && word_i) begin
        if (xend) begin
          busy_q <= 1'b0;
        end else if (bend) begin
          bcnt_q <= bsize_l;
          xcnt_q <= xcnt_q - 1'b1;
        end else begin
          bcnt_q <= bcnt_q - dec;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign burst_done_o = bd_q;
  assign xfer_done_o  = xd_q;
  assign irq_o        = irq_q;

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int STEP_W  = 16,
  parameter int SIZE_W  = 16,
  parameter int BURST_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              start_i,
  input  logic              word_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              busy_o,
  output logic              burst_done_o,
  output logic              xfer_done_o,
  output logic              irq_o
);

  localparam int NDIR = 2;  // index 0 source, 1 destination

  // shadow values
  logic [ADDR_W-1:0]  start_q [NDIR];
  logic [SIZE_W-1:0]  wsize_q [NDIR];
  logic [STEP_W-1:0]  bstep_q [NDIR];
  logic [STEP_W-1:0]  wstep_q [NDIR];
  logic [BURST_W-1:0] bsize_q;
  logic [SIZE_W-1:0]  xsize_q;
  mode_t              mode_q;

  logic load, adv, bend, en_clr;
  logic [ADDR_W-1:0] addr [NDIR];
  logic              dir;

  assign dir = cfg_sel_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NDIR; i++) begin
        start_q[i] <= '0;
        wsize_q[i] <= '0;
        bstep_q[i] <= '0;
        wstep_q[i] <= '0;
      end
      bsize_q <= '0;
      xsize_q <= '0;
      mode_q  <= '0;
    end else begin
      if (en_clr) mode_q.en <= 1'b0;
      if (cfg_we_i) begin
        case (cfg_sel_i)
          SEL_SRC_START, SEL_DST_START: start_q[dir] <= cfg_wdata_i;
          SEL_SRC_WSIZE, SEL_DST_WSIZE: wsize_q[dir] <= cfg_wdata_i[SIZE_W-1:0];
          SEL_SRC_BSTEP, SEL_DST_BSTEP: bstep_q[dir] <= cfg_wdata_i[STEP_W-1:0];
          SEL_SRC_WSTEP, SEL_DST_WSTEP: wstep_q[dir] <= cfg_wdata_i[STEP_W-1:0];
          SEL_BURST_SIZE: bsize_q <= cfg_wdata_i[BURST_W-1:0];
          SEL_XFER_SIZE:  xsize_q <= cfg_wdata_i[SIZE_W-1:0];
          SEL_MODE:       mode_q  <= mode_t'(cfg_wdata_i[3:0]);
          default: ;
        endcase
      end
    end
  end

  dma_seq_ctl #(
    .BURST_W(BURST_W),
    .SIZE_W (SIZE_W)
  ) ctl_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .word_i      (word_i),
    .mode_i      (mode_q),
    .burst_size_i(bsize_q),
    .xfer_size_i (xsize_q),
    .load_o      (load),
    .adv_o       (adv),
    .burst_end_o (bend),
    .en_clr_o    (en_clr),
    .busy_o      (busy_o),
    .burst_done_o(burst_done_o),
    .xfer_done_o (xfer_done_o),
    .irq_o       (irq_o)
  );

  for (genvar g = 0; g < NDIR; g++) begin : g_ptr
    dma_seq_ptr #(
      .ADDR_W(ADDR_W),
      .STEP_W(STEP_W),
      .SIZE_W(SIZE_W)
    ) ptr_i (
      .clk         (clk),
      .rst         (rst),
      .load_i      (load),
      .start_addr_i(start_q[g]),
      .wrap_size_i (wsize_q[g]),
      .burst_step_i(bstep_q[g]),
      .wrap_step_i (wstep_q[g]),
      .adv_i       (adv),
      .burst_end_i (bend),
      .addr_o      (addr[g])
    );
  end

  assign src_addr_o = addr[0];
  assign dst_addr_o = addr[1];

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              word_i,
  input logic              mode_en,
  input logic [ADDR_W-1:0] src_start,
  input logic [ADDR_W-1:0] dst_start,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic [ADDR_W-1:0] dst_addr_o,
  input logic              busy_o,
  input logic              burst_done_o,
  input logic              xfer_done_o
);

  // R2: an accepted start loads both shadow start addresses
  p_start_loads_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && mode_en) |=>
      (src_addr_o == $past(src_start)) && (dst_addr_o == $past(dst_start)) && busy_o);

  // R3: no strobe and no start means the pointers hold
  p_hold_without_word_r3: assert property (@(posedge clk) disable iff (rst)
    (!word_i && !start_i) |=> $stable(src_addr_o) && $stable(dst_addr_o));

  // R4: a burst-done flag is always caused by a word strobe one cycle earlier
  p_burst_from_word_r4: assert property (@(posedge clk) disable iff (rst)
    burst_done_o |-> $past(word_i));

  // R6: transfer end coincides with a burst end
  p_xfer_implies_burst_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_done_o |-> burst_done_o);

  // R6: channel is idle once the transfer has ended
  p_idle_after_done_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_done_o |-> !busy_o);

  // R6: idle strobes leave the addresses alone
  p_idle_word_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(src_addr_o) && $stable(dst_addr_o));

endmodule

bind dma_addr_seq dma_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .word_i      (word_i),
  .mode_en     (mode_q.en),
  .src_start   (start_q[0]),
  .dst_start   (start_q[1]),
  .src_addr_o  (src_addr_o),
  .dst_addr_o  (dst_addr_o),
  .busy_o      (busy_o),
  .burst_done_o(burst_done_o),
  .xfer_done_o (xfer_done_o)
);

// File: tb/dma_addr_seq_tb_top.sv
`timescale 1ns/1ps
module dma_addr_seq_tb_top;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we_i = 1'b0;
  logic [3:0]    cfg_sel_i = '0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic          start_i = 1'b0;
  logic          word_i = 1'b0;
  logic [AW-1:0] src_addr_o, dst_addr_o;
  logic          busy_o, burst_done_o, xfer_done_o, irq_o;

  always #2.5 clk = ~clk;

  dma_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .start_i(start_i), .word_i(word_i),
    .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o), .busy_o(busy_o),
    .burst_done_o(burst_done_o), .xfer_done_o(xfer_done_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [AW-1:0] s, d;
    logic          busy, bd, xd, irq;
    string         tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int   n_cmp = 0, n_bad = 0;

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares scoreboard items between edges
  always @(negedge clk) begin
    if (q.size() > 0) begin
      mon_e = q.pop_front();
      chk({mon_e.tag, " src"},   src_addr_o,          mon_e.s);
      chk({mon_e.tag, " dst"},   dst_addr_o,          mon_e.d);
      chk({mon_e.tag, " busy"},  AW'(busy_o),         AW'(mon_e.busy));
      chk({mon_e.tag, " bdone"}, AW'(burst_done_o),   AW'(mon_e.bd));
      chk({mon_e.tag, " xdone"}, AW'(xfer_done_o),    AW'(mon_e.xd));
      chk({mon_e.tag, " irq"},   AW'(irq_o),          AW'(mon_e.irq));
    end
  end

  // bench model of the programmed values
  logic [AW-1:0] st [2];
  int            wsz [2], bstep [2], wstep [2];
  int            bs, xs;
  bit            m_en, m_at_start, m_cont, m_wide;
  logic [AW-1:0] cur [2];
  bit            busy_m;

  task automatic push(logic [AW-1:0] s, logic [AW-1:0] d, bit b, bit bd, bit xd, bit irq, string tag);
    exp_t e;
    e.s = s; e.d = d; e.busy = b; e.bd = bd; e.xd = xd; e.irq = irq; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cfg(int sel, int data);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 4'(sel); cfg_wdata_i = AW'(data);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_mode(bit en, bit at_start, bit cont, bit wide);
    m_en = en; m_at_start = at_start; m_cont = cont; m_wide = wide;
    cfg(10, {28'd0, wide, cont, at_start, en});
  endtask

  task automatic program_all();
    cfg(0, int'(st[0]));  cfg(1, int'(st[1]));
    cfg(2, bs);           cfg(3, xs);
    cfg(4, wsz[0]);       cfg(5, wsz[1]);
    cfg(6, bstep[0]);     cfg(7, bstep[1]);
    cfg(8, wstep[0]);     cfg(9, wstep[1]);
  endtask

  task automatic do_start(string tag);
    bit acc;
    acc = m_en && !busy_m;
    @(negedge clk); start_i = 1'b1;
    @(posedge clk); #1; start_i = 1'b0;
    if (acc) begin
      cur[0] = st[0]; cur[1] = st[1]; busy_m = 1'b1;
    end
    push(cur[0], cur[1], busy_m, 1'b0, 1'b0, acc && m_at_start, tag);
  endtask

  task automatic idle_word(string tag);
    @(negedge clk); word_i = 1'b1;
    @(posedge clk); #1;
    push(cur[0], cur[1], busy_m, 1'b0, 1'b0, 1'b0, tag);
    @(negedge clk); word_i = 1'b0;
  endtask

  // drives a whole transfer and predicts each word from the requirements
  task automatic run_xfer(string tag);
    logic [AW-1:0] base [2];
    int            wc [2];
    int            nw;
    nw = m_wide ? (bs + 2) / 2 : bs + 1;
    for (int g = 0; g < 2; g++) begin base[g] = cur[g]; wc[g] = wsz[g]; end
    for (int b = 0; b <= xs; b++) begin
      for (int w = 0; w < nw; w++) begin
        bit lastb, lastx;
        lastb = (w == nw - 1);
        lastx = lastb && (b == xs);
        if (!lastx) begin
          for (int g = 0; g < 2; g++) begin
            if (lastb && wc[g] == 0) begin
              base[g] = base[g] + AW'(wstep[g]);
              cur[g]  = base[g];
              wc[g]   = wsz[g];
            end else begin
              if (lastb) wc[g]--;
              cur[g] = cur[g] + AW'(bstep[g]);
            end
          end
        end
        @(negedge clk); word_i = 1'b1;
        @(posedge clk); #1;
        if (lastx) begin
          busy_m = 1'b0;
          if (!m_cont) m_en = 1'b0;
        end
        push(cur[0], cur[1], !lastx, lastb, lastx, lastx && !m_at_start,
             $sformatf("%s b%0d w%0d", tag, b, w));
      end
    end
    @(negedge clk); word_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    busy_m = 1'b0; cur[0] = '0; cur[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    push('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 reset");
    @(negedge clk);

    // R2: disabled channel ignores start
    st[0] = 24'h000100; st[1] = 24'h002000;
    bs = 3; xs = 1; wsz[0] = 15; wsz[1] = 15;
    bstep[0] = 1; bstep[1] = -1; wstep[0] = 0; wstep[1] = 0;
    program_all();
    set_mode(1'b0, 1'b0, 1'b1, 1'b0);
    do_start("R2 start while disabled");

    // R2 R3 R4 R6 R8 R9: basic transfer, negative dst step, no wrap, irq at end
    set_mode(1'b1, 1'b0, 1'b1, 1'b0);
    do_start("R2 start load");
    run_xfer("R3 R4 R6 R8 R9 basic");
    idle_word("R6 idle word ignored");

    // R7: source wraps every burst, destination every two bursts with zero step
    st[0] = 24'h000400; st[1] = 24'h000800;
    bs = 1; xs = 3; wsz[0] = 0; wsz[1] = 1;
    bstep[0] = 2; bstep[1] = 0; wstep[0] = 'h40; wstep[1] = -'h10;
    program_all();
    do_start("R7 start");
    run_xfer("R7 wrap");

    // R5: 32-bit words, burst size 5 is three words
    st[0] = 24'h001000; st[1] = 24'h003000;
    bs = 5; xs = 1; wsz[0] = 15; wsz[1] = 15;
    bstep[0] = 2; bstep[1] = 2; wstep[0] = 0; wstep[1] = 0;
    program_all();
    set_mode(1'b1, 1'b0, 1'b1, 1'b1);
    do_start("R5 start");
    run_xfer("R5 wide");

    // R11 R2: writes and start during a transfer
    set_mode(1'b1, 1'b0, 1'b1, 1'b0);
    st[0] = 24'h000010; st[1] = 24'h000020;
    bs = 1; xs = 1; bstep[0] = 1; bstep[1] = 1;
    program_all();
    do_start("R11 start");
    cfg(0, 'h999);
    cfg(6, 5);
    do_start("R2 start while busy");
    run_xfer("R11 uses latched values");
    st[0] = 24'h000999; bstep[0] = 5;
    do_start("R11 new start uses new shadow");
    run_xfer("R11 second transfer");

    // R9 R10: interrupt at start, single-shot channel
    set_mode(1'b1, 1'b1, 1'b0, 1'b0);
    do_start("R9 irq at start");
    run_xfer("R9 R10 no end irq");
    do_start("R10 start after single shot ignored");
    set_mode(1'b1, 1'b1, 1'b0, 1'b0);
    do_start("R10 re-enabled start");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule